// File: doc/BRIEF.md
# Transceiver Interrupt Cause Register

This block gathers event pulses from a contactless transceiver and turns them into one active-high interrupt line for a host microcontroller. The events come from the transmitter, the receive framer, the FIFO fill level, the parity, framing, CRC and collision checkers, and an internal no-response timer. Each event sets its own bit in an eight-bit cause register. The host reads the register through a one-cycle read strobe. The read returns the causes and clears the register.

Transmit and receive bits are set when a frame begins. They raise the interrupt only when that frame finishes, so the host is not disturbed during a frame. Error, FIFO-threshold and timeout causes raise the interrupt at once.

The block contains three qualifiers:
- The CRC error is masked while a control bit says received CRC is not checked.
- Collisions are counted against a selectable threshold of 6 or 7.
- In the vicinity-card protocol mode, a prescaled timer reports when no receive start follows the end of a transmission within a programmable time.

Top module: `xcvr_irq_status`

## Requirements
- R1: After reset (`rst_n` low at a clock edge), all cause bits and `irq` are 0, and a read returns 0x00.
- R2: A `tx_start` pulse sets bit 7 without raising `irq`. A following `tx_end` pulse raises `irq` on the same clock edge it is sampled.
- R3: An `rx_sof` pulse sets bit 6 without raising `irq`. A following `rx_end` pulse raises `irq`.
- R4: Bit 5 and `irq` are set on the clock edge at which `fifo_level` first reaches or exceeds `fifo_hi_thr`, or first falls to or below `fifo_lo_thr`, measured against its value at the previous edge. A level that is held steady gives no further event. The level register resets to 0.
- R5: A `crc_err` pulse sets bit 4 and raises `irq` only while `crc_ignore` is 0. While `crc_ignore` is 1, the pulse changes neither the register nor `irq`.
- R6: A `parity_err` pulse sets bit 3 and a `frame_err` pulse sets bit 2. Each raises `irq` on the edge it is sampled.
- R7: A `coll_strobe` pulse sets bit 1 and raises `irq` when `coll_cnt` is at least 6 (`coll_sel`=0) or at least 7 (`coll_sel`=1). Below that threshold it has no effect.
- R8: With `vicinity_mode`=1, bit 0 and `irq` are set exactly `noresp_time` × PRESCALE clock edges after the edge that samples `tx_end`, with PRESCALE=8 by default. This happens only if no `rx_sof` is sampled in between.
- R9: An `rx_sof` pulse cancels a running no-response timer. With `vicinity_mode`=0, no timer is started and bit 0 is never set.
- R10: While `rd_stb` is 1, `rd_data` shows the cause register; otherwise `rd_data` is 0. The edge that samples `rd_stb` clears every cause bit and `irq`.
- R11: An event sampled on the same edge as a read is not lost. Its bit is set after the clear, and its interrupt rule applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Pulse: transmission began |
| tx_end | input | 1 | Pulse: transmission finished |
| rx_sof | input | 1 | Pulse: receive start of frame detected |
| rx_end | input | 1 | Pulse: reception finished |
| fifo_level | input | LW (5) | Current FIFO fill level |
| fifo_hi_thr | input | LW (5) | Upper fill threshold |
| fifo_lo_thr | input | LW (5) | Lower fill threshold |
| crc_err | input | 1 | Pulse: receive CRC mismatch |
| crc_ignore | input | 1 | 1 = received CRC is not checked |
| parity_err | input | 1 | Pulse: parity error |
| frame_err | input | 1 | Pulse: byte framing or end-of-frame error |
| coll_strobe | input | 1 | Pulse: end of a bit period, `coll_cnt` valid |
| coll_cnt | input | CW (3) | Collision samples seen in the bit period |
| coll_sel | input | 1 | Collision threshold: 0 selects 6, 1 selects 7 |
| vicinity_mode | input | 1 | 1 = vicinity-card protocol, timer enabled |
| noresp_time | input | TW (8) | No-response timeout in prescaled ticks |
| rd_stb | input | 1 | Host read strobe, one cycle |
| rd_data | output | 8 | Cause register while reading |
| irq | output | 1 | Active-high interrupt to the host |

## Verification
The bench checks that the transmit and receive bits stay silent until their frame-end pulse. A design that raises the line at frame start would show `irq` high one step too early.

It reads the register on the same edge as a parity event and on the exact edge the no-response timer expires. A design that lets the clear win would lose those bits on the next read.

The no-response test samples the read one edge before expiry and then once after expiry. An off-by-one tick count would move bit 0 into the wrong read. The bench also holds the FIFO level steady above the threshold, so a design that compares level rather than crossing would keep re-setting bit 5. It checks the CRC mask and both collision thresholds at the 6 boundary.

// File: rtl/xirq_pkg.sv
// Package: bit positions of the interrupt cause register and fixed
// constants shared by the interrupt status block and its helpers.
package xirq_pkg;
    localparam int CAUSE_W    = 8;
    localparam int B_TX       = 7;
    localparam int B_RX       = 6;
    localparam int B_FIFO     = 5;
    localparam int B_CRC      = 4;
    localparam int B_PARITY   = 3;
    localparam int B_FRAME    = 2;
    localparam int B_COLL     = 1;
    localparam int B_NORESP   = 0;
    localparam int COLL_THR_A = 6;
    localparam int COLL_THR_B = 7;

    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/xirq_fifo_cross.sv
// FIFO threshold crossing detector.
// Emits a one-cycle event when the fill level reaches the upper
// threshold from below, or falls to the lower threshold from above.
// Assumes the level input is synchronous to clk.
module xirq_fifo_cross #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] hi_thr,
    input  logic [LW-1:0] lo_thr,
    output logic          cross_evt
);
    logic [LW-1:0] prev_level;

    // Remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_level <= '0;
        else        prev_level <= level;
    end

    // Crossing in either direction gives the event.
    always_comb begin
        cross_evt = ((prev_level < hi_thr) && (level >= hi_thr)) ||
                    ((prev_level > lo_thr) && (level <= lo_thr));
    end

    // R4
    fifo_steady_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cross_evt |=> (!cross_evt || (level != $past(level))));
endmodule

// File: rtl/xirq_noresp_timer.sv
// No-response timer.
// Loads the timeout on end of transmission (when enabled) and counts it
// down in prescaled ticks. A receive start cancels it. The expire output
// is a one-cycle pulse on the tick that ends the timeout. A timeout of
// 0 behaves as 1 tick. Assumes PRESCALE >= 2.
module xirq_noresp_timer #(
    parameter int TW       = 8,
    parameter int PRESCALE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load,
    input  logic          cancel,
    input  logic [TW-1:0] timeout,
    output logic          expire
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_cnt;
    logic [TW-1:0] ticks_left;
    logic          armed;
    logic          tick;
    logic          start;

    // Decode tick and start conditions.
    always_comb begin
        tick   = (pre_cnt == PRE_LAST);
        start  = load && enable;
        expire = armed && tick && (ticks_left <= TW'(1)) && !cancel && !start;
    end

    // Arm, count down and disarm the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            pre_cnt    <= '0;
            ticks_left <= '0;
        end else if (cancel) begin
            armed <= 1'b0;
        end else if (start) begin
            armed      <= 1'b1;
            pre_cnt    <= '0;
            ticks_left <= timeout;
        end else if (armed) begin
            pre_cnt <= tick ? '0 : pre_cnt + PW'(1);
            if (tick) begin
                if (ticks_left <= TW'(1)) armed <= 1'b0;
                else                      ticks_left <= ticks_left - TW'(1);
            end
        end
    end

    // R9
    cancel_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !armed);
    // R8
    expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/xirq_flag_bank.sv
// Cause register and interrupt line.
// Merges new event bits into the register, clears it on a host read
// (events on the read edge survive), and decides when the interrupt
// line rises: frame bits wait for their frame-end pulse, all other
// bits raise it at once.
module xirq_flag_bank
    import xirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t set_vec,
    input  logic   tx_end,
    input  logic   rx_end,
    input  logic   rd_stb,
    output cause_t flags,
    output logic   irq
);
    cause_t flags_nxt;
    logic   raise;

    // Next register value and interrupt raise condition.
    always_comb begin
        flags_nxt = (rd_stb ? '0 : flags) | set_vec;
        raise     = (|set_vec[B_FIFO:B_NORESP]) ||
                    (tx_end && flags_nxt[B_TX]) ||
                    (rx_end && flags_nxt[B_RX]);
    end

    // Update the register and interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= flags_nxt;
            irq   <= (rd_stb ? 1'b0 : irq) | raise;
        end
    end

    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (set_vec == '0)) |=> ((flags == '0) && !irq));
    // R2
    frame_bits_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !tx_end && !rx_end && (set_vec[B_FIFO:B_NORESP] == '0)) |=> !irq);
    // R11
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
endmodule

// File: rtl/xcvr_irq_status.sv
// Transceiver interrupt status block (top).
// Qualifies the raw event pulses (CRC mask, collision threshold, FIFO
// crossing, no-response timeout), feeds them to the cause register and
// presents the register on a read strobe. All inputs are synchronous
// single-cycle pulses or levels on clk.
module xcvr_irq_status
    import xirq_pkg::*;
#(
    parameter int LW       = 5,
    parameter int CW       = 3,
    parameter int TW       = 8,
    parameter int PRESCALE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_start,
    input  logic          tx_end,
    input  logic          rx_sof,
    input  logic          rx_end,
    input  logic [LW-1:0] fifo_level,
    input  logic [LW-1:0] fifo_hi_thr,
    input  logic [LW-1:0] fifo_lo_thr,
    input  logic          crc_err,
    input  logic          crc_ignore,
    input  logic          parity_err,
    input  logic          frame_err,
    input  logic          coll_strobe,
    input  logic [CW-1:0] coll_cnt,
    input  logic          coll_sel,
    input  logic          vicinity_mode,
    input  logic [TW-1:0] noresp_time,
    input  logic          rd_stb,
    output logic [7:0]    rd_data,
    output logic          irq
);
    logic   fifo_evt;
    logic   noresp_evt;
    logic   coll_evt;
    cause_t set_vec;
    cause_t flags;

    xirq_fifo_cross #(.LW(LW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (fifo_level),
        .hi_thr    (fifo_hi_thr),
        .lo_thr    (fifo_lo_thr),
        .cross_evt (fifo_evt)
    );

    xirq_noresp_timer #(.TW(TW), .PRESCALE(PRESCALE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (vicinity_mode),
        .load    (tx_end),
        .cancel  (rx_sof),
        .timeout (noresp_time),
        .expire  (noresp_evt)
    );

    // Qualify raw events and assemble the set vector.
    always_comb begin
        coll_evt = coll_strobe &&
                   (coll_cnt >= (coll_sel ? CW'(COLL_THR_B) : CW'(COLL_THR_A)));
        set_vec           = '0;
        set_vec[B_TX]     = tx_start;
        set_vec[B_RX]     = rx_sof;
        set_vec[B_FIFO]   = fifo_evt;
        set_vec[B_CRC]    = crc_err && !crc_ignore;
        set_vec[B_PARITY] = parity_err;
        set_vec[B_FRAME]  = frame_err;
        set_vec[B_COLL]   = coll_evt;
        set_vec[B_NORESP] = noresp_evt;
    end

    xirq_flag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .tx_end  (tx_end),
        .rx_end  (rx_end),
        .rd_stb  (rd_stb),
        .flags   (flags),
        .irq     (irq)
    );

    // Present the register only while the host reads.
    always_comb rd_data = rd_stb ? flags : 8'h00;

    // R5
    crc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ignore && !flags[B_CRC]) |=> !flags[B_CRC]);
    // R9
    noresp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vicinity_mode && !flags[B_NORESP] && !$past(vicinity_mode)) |=> !flags[B_NORESP]);
endmodule

// File: tb/xcvr_irq_status_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the read task pushes expected bytes, a monitor pops
// and compares them while rd_stb is high.
module xcvr_irq_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_start = 0, tx_end = 0, rx_sof = 0, rx_end = 0;
    logic [4:0] fifo_level = 0, fifo_hi_thr = 5'd20, fifo_lo_thr = 5'd4;
    logic       crc_err = 0, crc_ignore = 0, parity_err = 0, frame_err = 0;
    logic       coll_strobe = 0, coll_sel = 0;
    logic [2:0] coll_cnt = 0;
    logic       vicinity_mode = 0;
    logic [7:0] noresp_time = 8'd3;
    logic       rd_stb = 0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    xcvr_irq_status uut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
        .rx_sof(rx_sof), .rx_end(rx_end), .fifo_level(fifo_level),
        .fifo_hi_thr(fifo_hi_thr), .fifo_lo_thr(fifo_lo_thr),
        .crc_err(crc_err), .crc_ignore(crc_ignore), .parity_err(parity_err),
        .frame_err(frame_err), .coll_strobe(coll_strobe), .coll_cnt(coll_cnt),
        .coll_sel(coll_sel), .vicinity_mode(vicinity_mode),
        .noresp_time(noresp_time), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    // Driver: read, queued expectation. Called just after a negedge.
    task automatic do_read(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Driver: one-cycle event pulse.
    task automatic pulse(input int which);
        case (which)
            0: tx_start = 1;   1: tx_end = 1;     2: rx_sof = 1;
            3: rx_end = 1;     4: crc_err = 1;    5: parity_err = 1;
            6: frame_err = 1;  default: coll_strobe = 1;
        endcase
        @(negedge clk);
        {tx_start, tx_end, rx_sof, rx_end} = '0;
        {crc_err, parity_err, frame_err, coll_strobe} = '0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        checks++;
        if (irq !== exp) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    // Monitor: compare read data against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_stb && exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    failures++;
                    $display("FAIL %s rd_data actual=%02h expected=%02h", t, rd_data, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(0, "R1");
        do_read(8'h00, "R1");

        // R2 transmit deferral
        pulse(0);
        chk_irq(0, "R2 before tx_end");
        pulse(1);
        chk_irq(1, "R2 after tx_end");
        do_read(8'h80, "R2");
        chk_irq(0, "R10 cleared by read");

        // R3 receive deferral
        pulse(2);
        chk_irq(0, "R3 before rx_end");
        pulse(3);
        chk_irq(1, "R3 after rx_end");
        do_read(8'h40, "R3");

        // R4 FIFO crossings
        fifo_level = 5'd10;
        @(negedge clk);
        chk_irq(0, "R4 below thresholds");
        fifo_level = 5'd22;
        @(negedge clk);
        chk_irq(1, "R4 upward crossing");
        do_read(8'h20, "R4 up");
        repeat (2) @(negedge clk);
        do_read(8'h00, "R4 steady level");
        fifo_level = 5'd3;
        @(negedge clk);
        do_read(8'h20, "R4 down");

        // R5 CRC mask
        crc_ignore = 1;
        pulse(4);
        chk_irq(0, "R5 masked");
        do_read(8'h00, "R5 masked");
        crc_ignore = 0;
        pulse(4);
        chk_irq(1, "R5 unmasked");
        do_read(8'h10, "R5 unmasked");

        // R6 parity and framing
        pulse(5);
        chk_irq(1, "R6 parity");
        do_read(8'h08, "R6 parity");
        pulse(6);
        chk_irq(1, "R6 framing");
        do_read(8'h04, "R6 framing");

        // R7 collision thresholds
        coll_sel = 0; coll_cnt = 3'd6;
        pulse(7);
        do_read(8'h02, "R7 six of six");
        coll_sel = 1; coll_cnt = 3'd6;
        pulse(7);
        chk_irq(0, "R7 six of seven");
        do_read(8'h00, "R7 six of seven");
        coll_cnt = 3'd7;
        pulse(7);
        do_read(8'h02, "R7 seven of seven");

        // R11 event on the read edge survives
        parity_err = 1;
        do_read(8'h00, "R11 read with event");
        parity_err = 0;
        chk_irq(1, "R11 irq kept");
        do_read(8'h08, "R11 event preserved");

        // R8 no-response timeout: 3 ticks x 8 = 24 edges after tx_end
        vicinity_mode = 1;
        noresp_time = 8'd3;
        pulse(0);
        pulse(1);
        repeat (23) @(negedge clk);
        do_read(8'h80, "R8 one edge before expiry");
        chk_irq(1, "R8 timeout irq");
        do_read(8'h01, "R8 timeout flag");

        // R9 cancel by receive start
        pulse(0);
        pulse(1);
        repeat (5) @(negedge clk);
        pulse(2);
        repeat (40) @(negedge clk);
        do_read(8'hC0, "R9 cancelled");

        // R9 mode gating
        vicinity_mode = 0;
        pulse(0);
        pulse(1);
        repeat (40) @(negedge clk);
        do_read(8'h80, "R9 mode off");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule